// File: doc/BRIEF.md
# Vertical Blanking Ancillary Line Gate

This block sits in a progressive video output path and decides, line by line, what reaches the output. On lines that carry picture content it forwards the pixel produced by the active-video path unchanged. On lines inside the vertical blanking interval it either lets ancillary data from the input through or replaces it with the blanking level. Which blanking lines are open depends on the selected progressive standard, 525-line or 625-line, and on a single enable bit.

The caller supplies the current line number, a start-of-frame strobe and a data-enable marking the active part of each line. The standard select and the enable are captured only on the start-of-frame strobe, so software may write them at any time without tearing a frame. The output is one registered pixel (luma and two chroma components, 10 bits each) and a flag that is high on every cycle of an open ancillary line.

Top module: `vbi_line_gate`

## Requirements
- R1: While reset is high and on the first cycle after it, the output is the blanking level (Y=64, Cr=512, Cb=512), the pass flag is 0, and the captured settings are 525-line standard with insertion disabled.
- R2: The output pixel and pass flag are registered and reflect the inputs of the previous clock cycle.
- R3: Active lines are 43 through 522 in 525-line mode and 45 through 620 in 625-line mode; on them the active-video pixel is output unchanged and the pass flag is 0, whatever the enable bit.
- R4: In 525-line mode (select = 0) with insertion enabled, lines 13 through 42 inclusive are open.
- R5: In 625-line mode (select = 1) with insertion enabled, lines 6 through 43 inclusive are open.
- R6: With insertion disabled, no line is open, the pass flag stays 0 and every non-active line outputs the blanking level.
- R7: Every line that is neither active nor open (including line numbers 0 and beyond the active range) outputs the blanking level with the pass flag at 0.
- R8: On an open line the pass flag is 1 on every cycle; while data-enable is 1 the ancillary input pixel is output unchanged, and while it is 0 the blanking level is output.
- R9: The select and enable inputs are captured on a cycle where the start-of-frame strobe is 1 and take effect from that cycle; changes at other times have no effect until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start-of-frame strobe, high on the first cycle of line 1 |
| line_i | input | 11 | Current line number, counted from 1 |
| de_i | input | 1 | High during the active part of the line |
| std_sel_i | input | 1 | Standard select: 0 = 525-line, 1 = 625-line progressive |
| vbi_open_i | input | 1 | Ancillary insertion enable |
| anc_y_i | input | 10 | Ancillary input luma |
| anc_cr_i | input | 10 | Ancillary input Cr |
| anc_cb_i | input | 10 | Ancillary input Cb |
| vid_y_i | input | 10 | Active-video path luma |
| vid_cr_i | input | 10 | Active-video path Cr |
| vid_cb_i | input | 10 | Active-video path Cb |
| out_y_o | output | 10 | Output luma |
| out_cr_o | output | 10 | Output Cr |
| out_cb_o | output | 10 | Output Cb |
| vbi_pass_o | output | 1 | High on an open ancillary line |

## Verification
The hardest situation to reach is a control write landing in the middle of a frame, where the output must keep following the settings captured at the last strobe rather than the pins. The stimulus flips both the select and the enable inputs partway through several frames, sometimes toward opening lines and sometimes toward closing them, and sweeps every line number of each standard so the first and last lines of both windows and of both active ranges are all met under each captured setting.

// File: rtl/vbi_gate_pkg.sv
package vbi_gate_pkg;

    localparam int PIX_W  = 10;
    localparam int LINE_W = 11;

    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        logic [PIX_W-1:0] y;
        logic [PIX_W-1:0] cr;
        logic [PIX_W-1:0] cb;
    } pix_t;

    typedef enum logic {
        STD_525P = 1'b0,
        STD_625P = 1'b1
    } std_e;

    typedef enum logic [1:0] {
        LK_ACTIVE   = 2'd0,
        LK_VBI_OPEN = 2'd1,
        LK_VBI_SHUT = 2'd2
    } line_kind_e;

    typedef struct packed {
        std_e std;
        logic open_en;
    } gate_cfg_t;

    localparam logic [PIX_W-1:0] BLANK_Y = PIX_W'(64);
    localparam logic [PIX_W-1:0] BLANK_C = PIX_W'(512);

    localparam line_t WIN525_FIRST = LINE_W'(13);
    localparam line_t WIN525_LAST  = LINE_W'(42);
    localparam line_t WIN625_FIRST = LINE_W'(6);
    localparam line_t WIN625_LAST  = LINE_W'(43);
    localparam line_t ACT525_FIRST = LINE_W'(43);
    localparam line_t ACT525_LAST  = LINE_W'(522);
    localparam line_t ACT625_FIRST = LINE_W'(45);
    localparam line_t ACT625_LAST  = LINE_W'(620);

    localparam gate_cfg_t CFG_RESET = '{std: STD_525P, open_en: 1'b0};

    function automatic pix_t blank_pix();
        pix_t p;
        p.y  = BLANK_Y;
        p.cr = BLANK_C;
        p.cb = BLANK_C;
        return p;
    endfunction

    function automatic logic line_is_active(std_e s, line_t l);
        if (s == STD_625P)
            return (l >= ACT625_FIRST) && (l <= ACT625_LAST);
        return (l >= ACT525_FIRST) && (l <= ACT525_LAST);
    endfunction

    function automatic logic line_in_window(std_e s, line_t l);
        if (s == STD_625P)
            return (l >= WIN625_FIRST) && (l <= WIN625_LAST);
        return (l >= WIN525_FIRST) && (l <= WIN525_LAST);
    endfunction

endpackage

// File: rtl/vbi_cfg_shadow.sv
module vbi_cfg_shadow
    import vbi_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sof_i,
    input  gate_cfg_t cfg_i,
    output gate_cfg_t cfg_eff_o
);

    gate_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else if (sof_i)
            cfg_q <= cfg_i;
    end

    // The strobe cycle already belongs to the new frame.
    assign cfg_eff_o = sof_i ? cfg_i : cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sof_i |=> $stable(cfg_q)); // R9

    AST_CFG_TAKE: assert property (@(posedge clk) disable iff (rst)
        sof_i |=> cfg_q == $past(cfg_i)); // R9

endmodule

// File: rtl/vbi_line_class.sv
module vbi_line_class
    import vbi_gate_pkg::*;
(
    input  gate_cfg_t  cfg_i,
    input  line_t      line_i,
    output line_kind_e kind_o
);

    logic is_act;
    logic in_win;

    always_comb begin
        is_act = line_is_active(cfg_i.std, line_i);
        in_win = line_in_window(cfg_i.std, line_i);
        if (is_act)
            kind_o = LK_ACTIVE;
        else if (cfg_i.open_en && in_win)
            kind_o = LK_VBI_OPEN;
        else
            kind_o = LK_VBI_SHUT;
    end

endmodule

// File: rtl/vbi_out_stage.sv
module vbi_out_stage
    import vbi_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_kind_e kind_i,
    input  logic       de_i,
    input  pix_t       anc_i,
    input  pix_t       vid_i,
    output pix_t       pix_o,
    output logic       pass_o
);

    pix_t pix_d;
    logic pass_d;

    always_comb begin
        pix_d  = blank_pix();
        pass_d = 1'b0;
        unique case (kind_i)
            LK_ACTIVE:   pix_d = vid_i;
            LK_VBI_OPEN: begin
                pass_d = 1'b1;
                if (de_i)
                    pix_d = anc_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_o  <= blank_pix();
            pass_o <= 1'b0;
        end else begin
            pix_o  <= pix_d;
            pass_o <= pass_d;
        end
    end

    AST_SHUT_BLANK: assert property (@(posedge clk) disable iff (rst)
        kind_i == LK_VBI_SHUT |=> (pix_o == blank_pix()) && !pass_o); // R7

    AST_ACTIVE_THRU: assert property (@(posedge clk) disable iff (rst)
        kind_i == LK_ACTIVE |=> (pix_o == $past(vid_i)) && !pass_o); // R3

    AST_OPEN_DATA: assert property (@(posedge clk) disable iff (rst)
        (kind_i == LK_VBI_OPEN) && de_i |=> (pix_o == $past(anc_i)) && pass_o); // R8

    AST_OPEN_HBLANK: assert property (@(posedge clk) disable iff (rst)
        (kind_i == LK_VBI_OPEN) && !de_i |=> (pix_o == blank_pix()) && pass_o); // R8

endmodule

// File: rtl/vbi_line_gate.sv
module vbi_line_gate
    import vbi_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sof_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              de_i,
    input  logic              std_sel_i,
    input  logic              vbi_open_i,
    input  logic [PIX_W-1:0]  anc_y_i,
    input  logic [PIX_W-1:0]  anc_cr_i,
    input  logic [PIX_W-1:0]  anc_cb_i,
    input  logic [PIX_W-1:0]  vid_y_i,
    input  logic [PIX_W-1:0]  vid_cr_i,
    input  logic [PIX_W-1:0]  vid_cb_i,
    output logic [PIX_W-1:0]  out_y_o,
    output logic [PIX_W-1:0]  out_cr_o,
    output logic [PIX_W-1:0]  out_cb_o,
    output logic              vbi_pass_o
);

    gate_cfg_t  cfg_in;
    gate_cfg_t  cfg_eff;
    line_kind_e kind;
    pix_t       anc_pix;
    pix_t       vid_pix;
    pix_t       out_pix;

    assign cfg_in.std     = std_e'(std_sel_i);
    assign cfg_in.open_en = vbi_open_i;

    assign anc_pix = '{y: anc_y_i, cr: anc_cr_i, cb: anc_cb_i};
    assign vid_pix = '{y: vid_y_i, cr: vid_cr_i, cb: vid_cb_i};

    vbi_cfg_shadow u_cfg (
        .clk       (clk),
        .rst       (rst),
        .sof_i     (sof_i),
        .cfg_i     (cfg_in),
        .cfg_eff_o (cfg_eff)
    );

    vbi_line_class u_class (
        .cfg_i  (cfg_eff),
        .line_i (line_i),
        .kind_o (kind)
    );

    vbi_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .kind_i (kind),
        .de_i   (de_i),
        .anc_i  (anc_pix),
        .vid_i  (vid_pix),
        .pix_o  (out_pix),
        .pass_o (vbi_pass_o)
    );

    assign out_y_o  = out_pix.y;
    assign out_cr_o = out_pix.cr;
    assign out_cb_o = out_pix.cb;

    AST_OFF_NO_PASS: assert property (@(posedge clk) disable iff (rst)
        !cfg_eff.open_en |=> !vbi_pass_o); // R6

    AST_ACTIVE_NO_PASS: assert property (@(posedge clk) disable iff (rst)
        line_is_active(cfg_eff.std, line_i) |=> !vbi_pass_o); // R3

    AST_OPEN_ONLY_BLANKING: assert property (@(posedge clk) disable iff (rst)
        kind == LK_VBI_OPEN |-> line_i < (cfg_eff.std == STD_625P ? ACT625_FIRST : ACT525_FIRST)); // R4 R5

endmodule

// File: tb/vbi_line_gate_bench.sv
module vbi_line_gate_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CYC_PER_LINE = 4;
    localparam int WATCHDOG_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof_i = 1'b0;
    logic [10:0] line_i = '0;
    logic        de_i = 1'b0;
    logic        std_sel_i = 1'b0;
    logic        vbi_open_i = 1'b0;
    logic [9:0]  anc_y_i = '0, anc_cr_i = '0, anc_cb_i = '0;
    logic [9:0]  vid_y_i = '0, vid_cr_i = '0, vid_cb_i = '0;
    logic [9:0]  out_y_o, out_cr_o, out_cb_o;
    logic        vbi_pass_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    bit m_std = 0;
    bit m_en  = 0;
    bit exp_valid = 0;
    int exp_y, exp_cr, exp_cb;
    bit exp_pass;
    string exp_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbi_line_gate u_vbi_line_gate (
        .clk(clk), .rst(rst), .sof_i(sof_i), .line_i(line_i), .de_i(de_i),
        .std_sel_i(std_sel_i), .vbi_open_i(vbi_open_i),
        .anc_y_i(anc_y_i), .anc_cr_i(anc_cr_i), .anc_cb_i(anc_cb_i),
        .vid_y_i(vid_y_i), .vid_cr_i(vid_cr_i), .vid_cb_i(vid_cb_i),
        .out_y_o(out_y_o), .out_cr_o(out_cr_o), .out_cb_o(out_cb_o),
        .vbi_pass_o(vbi_pass_o)
    );

    task automatic check_out(string tag, int ey, int ecr, int ecb, bit ep);
        checks++;
        if (out_y_o !== 10'(ey) || out_cr_o !== 10'(ecr) ||
            out_cb_o !== 10'(ecb) || vbi_pass_o !== ep) begin
            failures++;
            $display("FAIL %s: got y=%0d cr=%0d cb=%0d pass=%0b, expected y=%0d cr=%0d cb=%0d pass=%0b",
                     tag, out_y_o, out_cr_o, out_cb_o, vbi_pass_o, ey, ecr, ecb, ep);
        end
    endtask

    // Drive one cycle of input, compare the result of the previous cycle.
    task automatic step(bit sof, int line, bit de, bit std, bit en);
        bit act, win, pinned;
        @(negedge clk);
        if (exp_valid) check_out(exp_tag, exp_y, exp_cr, exp_cb, exp_pass);
        sof_i = sof; line_i = 11'(line); de_i = de;
        std_sel_i = std; vbi_open_i = en;
        anc_y_i = 10'($urandom); anc_cr_i = 10'($urandom); anc_cb_i = 10'($urandom);
        vid_y_i = 10'($urandom); vid_cr_i = 10'($urandom); vid_cb_i = 10'($urandom);
        if (sof) begin m_std = std; m_en = en; end
        pinned = (std != m_std) || (en != m_en);
        if (m_std) begin
            act = (line >= 45 && line <= 620);
            win = (line >= 6 && line <= 43);
        end else begin
            act = (line >= 43 && line <= 522);
            win = (line >= 13 && line <= 42);
        end
        if (act) begin
            exp_y = vid_y_i; exp_cr = vid_cr_i; exp_cb = vid_cb_i; exp_pass = 0;
            exp_tag = "R2/R3";
        end else if (m_en && win) begin
            exp_pass = 1;
            if (de) begin
                exp_y = anc_y_i; exp_cr = anc_cr_i; exp_cb = anc_cb_i;
            end else begin
                exp_y = 64; exp_cr = 512; exp_cb = 512;
            end
            exp_tag = m_std ? "R5/R8" : "R4/R8";
        end else begin
            exp_y = 64; exp_cr = 512; exp_cb = 512; exp_pass = 0;
            exp_tag = m_en ? "R7" : "R6/R7";
        end
        if (pinned) exp_tag = {exp_tag, "/R9"};
        exp_valid = 1;
    endtask

    // One full frame; optionally flip both controls at a given line without a strobe.
    task automatic run_frame(bit std, bit en, int flip_line);
        int total;
        bit cs, ce;
        total = std ? 625 : 525;
        cs = std; ce = en;
        for (int l = 1; l <= total; l++) begin
            if (l == flip_line) begin cs = ~cs; ce = ~ce; end
            for (int c = 0; c < CYC_PER_LINE; c++)
                step((l == 1) && (c == 0), l, (c == 1) || (c == 2), cs, ce);
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state, inputs trying to open a line
        std_sel_i = 1; vbi_open_i = 1; sof_i = 1; line_i = 11'd10; de_i = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_out("R1 during reset", 64, 512, 512, 0);
        rst = 0; sof_i = 0; line_i = 11'd20;
        @(negedge clk);
        check_out("R1 after reset", 64, 512, 512, 0);
        // R1: captured settings are 525 disabled: line 20 without strobe stays shut
        step(0, 20, 1, 1, 1);
        step(0, 5, 1, 1, 1);

        run_frame(0, 1, 0);     // R4
        run_frame(1, 1, 0);     // R5
        run_frame(0, 0, 0);     // R6
        run_frame(1, 0, 8);     // R9: enable rises mid-frame, ignored
        run_frame(1, 1, 20);    // R9: controls drop mid-frame, ignored
        run_frame(0, 1, 30);    // R9
        // R7: out-of-range line numbers after a frame
        step(1, 0, 1, 1, 1);
        step(0, 700, 1, 1, 1);
        step(0, 621, 1, 1, 1);
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        check_out(exp_tag, exp_y, exp_cr, exp_cb, exp_pass);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule